// File: doc/BRIEF.md
# Board Control Register Bank

This block is a handful of byte-wide control registers that sit behind one chip-enable window of a processor's asynchronous external memory bus. A bus write to one of four offsets updates a register on the next clock edge; a bus read returns the selected register combinationally while the read strobe is held. The registers steer the board's housekeeping hardware: two status LEDs, a software-driven open-drain two-wire (I2C) port, the kick line of an external reset supervisor, and the top address line of the boot flash. A read-only register reports the strapped processor speed grade.

The green LED can follow bus activity as well as being switched by software. It can light whenever the shared chip-enable space is in use, or only while the flash is being accessed. The I2C register reports the line levels actually present on the wires, sampled through a synchronizer. A status bit therefore reads low when any device on the bus holds the line down, even if this block has released it. The watchdog bit never holds state: each write of 1 produces one single-cycle pulse.

Top module: `board_ctl_regs`

## Requirements
- R1: After reset the LED register (offset 0) reads 0x30, the I2C register (offset 1) reads 0xF0 with both lines idle high, the control register (offset 2) reads 0x00, and led_red, wdog_kick, flash_hi_addr, sda_pull and scl_pull are all 0.
- R2: In the LED register, bits 7:6 hold the red LED code and bits 5:4 hold the green LED code. Both fields are read/write. Bits 3:0 ignore writes and read 0.
- R3: led_red is 1 only for red code 01. Codes 00, 10 and 11 keep it off. It changes right after the write edge.
- R4: The green code selects what drives led_green. 00 is off and 01 is on. 10 follows ce_active and 11 follows flash_access, each delayed by one clock register.
- R5: In the I2C register, bit 6 controls SDA and bit 4 controls SCL. Writing 0 sets the matching pull output (drive low) and writing 1 clears it. Bits 3:0 ignore writes and read 0.
- R6: I2C register bit 7 reads the SDA line level and bit 5 reads the SCL line level, each after SYNC_STAGES clocks. A line held low by an external device reads 0 while the control bit is 1.
- R7: Writing the control register with bit 0 set raises wdog_kick for exactly the one cycle after the write edge. Writing bit 0 as 0 gives no pulse, and bit 0 always reads 0.
- R8: Control register bit 1 is read/write and drives flash_hi_addr. 0 selects the lower flash half. It changes only on a control register write.
- R9: The config register (offset 3) reads speed_strap in bit 0 and 0 in bits 7:1. Writes to it have no effect.
- R10: Registers are selected by bus_addr[1:0] and only when the upper address bits are zero. Writes without bus_cs, or to a nonzero upper address, are ignored. bus_rdata is 0 unless bus_cs and bus_re are both high and the address hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs | input | 1 | Chip-enable for the register window |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address within the window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when not reading |
| ce_active | input | 1 | Shared chip-enable space in use |
| flash_access | input | 1 | Flash device in use |
| speed_strap | input | 1 | Speed grade strap, 0 = 225 MHz, 1 = 300 MHz |
| sda_in | input | 1 | Observed SDA line level |
| scl_in | input | 1 | Observed SCL line level |
| sda_pull | output | 1 | 1 drives SDA low |
| scl_pull | output | 1 | 1 drives SCL low |
| wdog_kick | output | 1 | Single-cycle watchdog kick pulse |
| flash_hi_addr | output | 1 | Flash top address line |
| led_red | output | 1 | Red LED drive |
| led_green | output | 1 | Green LED drive |

## Verification
The bench drives the reserved red codes, which must keep the LED dark; a design that decoded only bit 6 would light it for code 11. It checks that activity mode 10 ignores flash_access and mode 11 ignores ce_active; a swapped or merged decode shows up at once. It pulls SDA from the outside while the control bit stays released, which catches a design that reads back the written bit instead of the line. It also counts the kick pulse cycle by cycle and writes with bus_cs low and with a high address. A sticky or doubled kick, or an aliased address decode, would change a port value there.

// File: rtl/board_ctl_pkg.sv
package board_ctl_pkg;

    localparam int SEL_W = 2;

    localparam logic [SEL_W-1:0] SEL_LED  = 2'd0;
    localparam logic [SEL_W-1:0] SEL_I2C  = 2'd1;
    localparam logic [SEL_W-1:0] SEL_CTRL = 2'd2;
    localparam logic [SEL_W-1:0] SEL_CFG  = 2'd3;

    // writable bits of each register
    localparam logic [7:0] LED_WMASK  = 8'hF0;
    localparam logic [7:0] I2C_WMASK  = 8'h50;
    localparam logic [7:0] CTRL_WMASK = 8'h03;

    localparam int KICK_BIT = 0;
    localparam int BANK_BIT = 1;

    typedef enum logic [1:0] {
        LM_OFF   = 2'b00,
        LM_ON    = 2'b01,
        LM_CE    = 2'b10,
        LM_FLASH = 2'b11
    } led_mode_e;

    typedef struct packed {
        logic [1:0] red;
        led_mode_e  green;
    } led_cfg_t;

    localparam led_cfg_t LED_RESET = '{red: 2'b00, green: LM_FLASH};

    typedef struct packed {
        logic led;
        logic i2c;
        logic ctrl;
        logic cfg;
    } reg_sel_t;

    function automatic reg_sel_t decode_sel(input logic hit, input logic [SEL_W-1:0] sel);
        reg_sel_t s;
        s.led  = hit && (sel == SEL_LED);
        s.i2c  = hit && (sel == SEL_I2C);
        s.ctrl = hit && (sel == SEL_CTRL);
        s.cfg  = hit && (sel == SEL_CFG);
        return s;
    endfunction

    function automatic logic green_lit(input led_mode_e m, input logic ce, input logic fl);
        case (m)
            LM_ON:    return 1'b1;
            LM_CE:    return ce;
            LM_FLASH: return fl;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/bcr_led_ctl.sv
module bcr_led_ctl
    import board_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    input  logic       ce_active,
    input  logic       flash_access,
    output logic [7:0] rd_byte,
    output logic       led_red,
    output logic       led_green
);
    led_cfg_t   cfg_q;
    logic       ce_q;
    logic       fl_q;
    logic [7:0] wmasked;

    assign wmasked = wdata & LED_WMASK;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= LED_RESET;
            ce_q  <= 1'b0;
            fl_q  <= 1'b0;
        end else begin
            ce_q <= ce_active;
            fl_q <= flash_access;
            if (wr_en) begin
                cfg_q <= led_cfg_t'(wmasked[7:4]);
            end
        end
    end

    assign rd_byte   = {cfg_q, 4'b0000};
    assign led_red   = (cfg_q.red == 2'b01);
    assign led_green = green_lit(cfg_q.green, ce_q, fl_q);

endmodule

// File: rtl/bcr_i2c_port.sv
module bcr_i2c_port
    import board_ctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    input  logic       sda_in,
    input  logic       scl_in,
    output logic       sda_pull,
    output logic       scl_pull,
    output logic [7:0] rd_byte
);
    localparam int LAST = SYNC_STAGES - 1;

    logic                   sda_ctl_q;
    logic                   scl_ctl_q;
    logic [SYNC_STAGES-1:0] sda_sync;
    logic [SYNC_STAGES-1:0] scl_sync;
    logic [7:0]             wmasked;

    assign wmasked = wdata & I2C_WMASK;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    sda_sync <= '1;
                    scl_sync <= '1;
                end else begin
                    sda_sync <= sda_in;
                    scl_sync <= scl_in;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    sda_sync <= '1;
                    scl_sync <= '1;
                end else begin
                    sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_in};
                    scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_in};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            sda_ctl_q <= 1'b1;
            scl_ctl_q <= 1'b1;
        end else if (wr_en) begin
            sda_ctl_q <= wmasked[6];
            scl_ctl_q <= wmasked[4];
        end
    end

    assign sda_pull = ~sda_ctl_q;
    assign scl_pull = ~scl_ctl_q;
    assign rd_byte  = {sda_sync[LAST], sda_ctl_q, scl_sync[LAST], scl_ctl_q, 4'b0000};

endmodule

// File: rtl/bcr_misc_ctl.sv
module bcr_misc_ctl
    import board_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    input  logic       speed_strap,
    output logic       wdog_kick,
    output logic       flash_hi_addr,
    output logic [7:0] ctrl_rd,
    output logic [7:0] cfg_rd
);
    logic [7:0] wmasked;
    logic       bank_q;
    logic       kick_q;

    assign wmasked = wdata & CTRL_WMASK;

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= 1'b0;
            kick_q <= 1'b0;
        end else begin
            kick_q <= wr_en && wmasked[KICK_BIT];
            if (wr_en) begin
                bank_q <= wmasked[BANK_BIT];
            end
        end
    end

    assign wdog_kick     = kick_q;
    assign flash_hi_addr = bank_q;
    assign ctrl_rd       = {6'b0, bank_q, 1'b0};
    assign cfg_rd        = {7'b0, speed_strap};

endmodule

// File: rtl/board_ctl_regs.sv
module board_ctl_regs
    import board_ctl_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_cs,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              ce_active,
    input  logic              flash_access,
    input  logic              speed_strap,
    input  logic              sda_in,
    input  logic              scl_in,
    output logic              sda_pull,
    output logic              scl_pull,
    output logic              wdog_kick,
    output logic              flash_hi_addr,
    output logic              led_red,
    output logic              led_green
);
    logic       addr_hit;
    reg_sel_t   sel;
    logic       wr;
    logic       rd;
    logic [7:0] led_rd;
    logic [7:0] i2c_rd;
    logic [7:0] ctrl_rd;
    logic [7:0] cfg_rd;

    assign addr_hit = ((bus_addr >> SEL_W) == '0);
    assign sel      = decode_sel(addr_hit, bus_addr[SEL_W-1:0]);
    assign wr       = bus_cs && bus_we;
    assign rd       = bus_cs && bus_re;

    bcr_led_ctl u_led (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr && sel.led),
        .wdata        (bus_wdata),
        .ce_active    (ce_active),
        .flash_access (flash_access),
        .rd_byte      (led_rd),
        .led_red      (led_red),
        .led_green    (led_green)
    );

    bcr_i2c_port #(.SYNC_STAGES(SYNC_STAGES)) u_i2c (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr && sel.i2c),
        .wdata    (bus_wdata),
        .sda_in   (sda_in),
        .scl_in   (scl_in),
        .sda_pull (sda_pull),
        .scl_pull (scl_pull),
        .rd_byte  (i2c_rd)
    );

    bcr_misc_ctl u_misc (
        .clk           (clk),
        .rst           (rst),
        .wr_en         (wr && sel.ctrl),
        .wdata         (bus_wdata),
        .speed_strap   (speed_strap),
        .wdog_kick     (wdog_kick),
        .flash_hi_addr (flash_hi_addr),
        .ctrl_rd       (ctrl_rd),
        .cfg_rd        (cfg_rd)
    );

    always_comb begin
        bus_rdata = 8'h00;
        if (rd) begin
            unique case (1'b1)
                sel.led:  bus_rdata = led_rd;
                sel.i2c:  bus_rdata = i2c_rd;
                sel.ctrl: bus_rdata = ctrl_rd;
                sel.cfg:  bus_rdata = cfg_rd;
                default:  bus_rdata = 8'h00;
            endcase
        end
    end

endmodule

// File: rtl/bcr_checker.sv
module bcr_checker #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_cs,
    input logic              bus_we,
    input logic              bus_re,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              led_red,
    input logic              sda_pull,
    input logic              wdog_kick,
    input logic              flash_hi_addr
);
    localparam logic [ADDR_W-1:0] A_LED  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_I2C  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(2);

    logic wr_led, wr_i2c, wr_ctrl;
    assign wr_led  = bus_cs && bus_we && (bus_addr == A_LED);
    assign wr_i2c  = bus_cs && bus_we && (bus_addr == A_I2C);
    assign wr_ctrl = bus_cs && bus_we && (bus_addr == A_CTRL);

    // R3: a red code other than 01 leaves the red LED dark
    p_red_dark_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_led && ((bus_wdata & 8'hC0) != 8'h40)) |=> !led_red);

    // R5: a control bit written 0 pulls SDA
    p_sda_drive_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_i2c && ((bus_wdata & 8'h40) == 8'h00)) |=> sda_pull);

    // R7: each kick pulse comes from a kick write one cycle earlier
    p_kick_cause_r7: assert property (@(posedge clk) disable iff (rst)
        wdog_kick |-> $past(wr_ctrl && ((bus_wdata & 8'h01) != 8'h00)));

    // R7: a kick write always produces the pulse
    p_kick_fire_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && ((bus_wdata & 8'h01) != 8'h00)) |=> wdog_kick);

    // R8: the flash bank line moves only on a control write
    p_bank_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !wr_ctrl |=> $stable(flash_hi_addr));

    // R10: read data is zero outside a read cycle
    p_idle_rdata_r10: assert property (@(posedge clk) disable iff (rst)
        !(bus_cs && bus_re) |-> (bus_rdata == 8'h00));

endmodule

bind board_ctl_regs bcr_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .bus_cs        (bus_cs),
    .bus_we        (bus_we),
    .bus_re        (bus_re),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .led_red       (led_red),
    .sda_pull      (sda_pull),
    .wdog_kick     (wdog_kick),
    .flash_hi_addr (flash_hi_addr)
);

// File: tb/board_ctl_regs_tb_top.sv
`timescale 1ns/1ps
module board_ctl_regs_tb_top;
    localparam int ADDR_W = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_cs = 1'b0, bus_we = 1'b0, bus_re = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [7:0]        bus_wdata = 8'h00;
    logic [7:0]        bus_rdata;
    logic              ce_active = 1'b0, flash_access = 1'b0, speed_strap = 1'b0;
    logic              ext_sda_low = 1'b0, ext_scl_low = 1'b0;
    logic              sda_in, scl_in, sda_pull, scl_pull;
    logic              wdog_kick, flash_hi_addr, led_red, led_green;

    int checks = 0;
    int failures = 0;

    // wired-AND lines with pull-ups
    assign sda_in = ~(sda_pull | ext_sda_low);
    assign scl_in = ~(scl_pull | ext_scl_low);

    always #10 clk = ~clk;

    board_ctl_regs #(.ADDR_W(ADDR_W), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst), .bus_cs(bus_cs), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ce_active(ce_active), .flash_access(flash_access), .speed_strap(speed_strap),
        .sda_in(sda_in), .scl_in(scl_in), .sda_pull(sda_pull), .scl_pull(scl_pull),
        .wdog_kick(wdog_kick), .flash_hi_addr(flash_hi_addr),
        .led_red(led_red), .led_green(led_green)
    );

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // leaves the caller at the negedge after the write edge
    task automatic bus_write(input logic cs, input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_cs = cs; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_cs = 1'b0; bus_we = 1'b0; bus_wdata = 8'h00;
    endtask

    task automatic bus_read(input logic cs, input logic [ADDR_W-1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_cs = cs; bus_re = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        bus_cs = 1'b0; bus_re = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        bus_read(1'b1, 4'd0, v); check("R1", "LED reg", v, 8'h30);
        bus_read(1'b1, 4'd1, v); check("R1", "I2C reg", v, 8'hF0);
        bus_read(1'b1, 4'd2, v); check("R1", "CTRL reg", v, 8'h00);
        check("R1", "led_red", {7'b0, led_red}, 8'h00);
        check("R1", "kick/bank/pulls", {4'b0, wdog_kick, flash_hi_addr, sda_pull, scl_pull}, 8'h00);
    endtask

    task automatic t_led();
        logic [7:0] v;
        bus_write(1'b1, 4'd0, 8'h5F);
        check("R3", "red code 01 lit", {7'b0, led_red}, 8'h01);
        bus_read(1'b1, 4'd0, v); check("R2", "LED fields, reserved zero", v, 8'h50);
        check("R4", "green mode on", {7'b0, led_green}, 8'h01);
        bus_write(1'b1, 4'd0, 8'h80);
        check("R3", "red code 10 dark", {7'b0, led_red}, 8'h00);
        check("R4", "green mode off", {7'b0, led_green}, 8'h00);
        // green mode 10 follows ce_active only; red code 11 stays dark
        bus_write(1'b1, 4'd0, 8'hE0);
        check("R3", "red code 11 dark", {7'b0, led_red}, 8'h00);
        ce_active = 1'b1; @(negedge clk);
        check("R4", "mode 10 ce high", {7'b0, led_green}, 8'h01);
        ce_active = 1'b0; flash_access = 1'b1; @(negedge clk);
        check("R4", "mode 10 ignores flash", {7'b0, led_green}, 8'h00);
        // green mode 11 follows flash_access only
        bus_write(1'b1, 4'd0, 8'h30);
        check("R4", "mode 11 flash high", {7'b0, led_green}, 8'h01);
        flash_access = 1'b0; ce_active = 1'b1; @(negedge clk);
        check("R4", "mode 11 ignores ce", {7'b0, led_green}, 8'h00);
        ce_active = 1'b0;
    endtask

    task automatic t_i2c();
        logic [7:0] v;
        bus_write(1'b1, 4'd1, 8'h00);
        check("R5", "both pulls on", {6'b0, sda_pull, scl_pull}, 8'h03);
        wait_cycles(3);
        bus_read(1'b1, 4'd1, v); check("R6", "lines read low", v, 8'h00);
        bus_write(1'b1, 4'd1, 8'hFF);
        check("R5", "both pulls off", {6'b0, sda_pull, scl_pull}, 8'h00);
        wait_cycles(3);
        bus_read(1'b1, 4'd1, v); check("R5", "released, reserved zero", v, 8'hF0);
        ext_sda_low = 1'b1; wait_cycles(3);
        bus_read(1'b1, 4'd1, v); check("R6", "external SDA hold", v, 8'h70);
        ext_sda_low = 1'b0; ext_scl_low = 1'b1; wait_cycles(3);
        bus_read(1'b1, 4'd1, v); check("R6", "external SCL hold", v, 8'hD0);
        ext_scl_low = 1'b0; wait_cycles(3);
    endtask

    task automatic t_wdog_bank();
        logic [7:0] v;
        bus_write(1'b1, 4'd2, 8'h01);
        check("R7", "kick pulse high", {7'b0, wdog_kick}, 8'h01);
        @(negedge clk);
        check("R7", "kick pulse ends", {7'b0, wdog_kick}, 8'h00);
        bus_read(1'b1, 4'd2, v); check("R7", "kick bit reads 0", v, 8'h00);
        bus_write(1'b1, 4'd2, 8'h02);
        check("R7", "no kick on 0", {7'b0, wdog_kick}, 8'h00);
        check("R8", "flash bank high", {7'b0, flash_hi_addr}, 8'h01);
        bus_read(1'b1, 4'd2, v); check("R8", "bank readback", v, 8'h02);
        bus_write(1'b1, 4'd2, 8'h00);
        check("R8", "flash bank low", {7'b0, flash_hi_addr}, 8'h00);
    endtask

    task automatic t_cfg();
        logic [7:0] v;
        speed_strap = 1'b1;
        bus_read(1'b1, 4'd3, v); check("R9", "speed 300", v, 8'h01);
        speed_strap = 1'b0;
        bus_write(1'b1, 4'd3, 8'hFF);
        bus_read(1'b1, 4'd3, v); check("R9", "speed 225, write ignored", v, 8'h00);
        bus_read(1'b1, 4'd0, v); check("R9", "LED untouched by cfg write", v, 8'h30);
    endtask

    task automatic t_decode();
        logic [7:0] v;
        bus_write(1'b0, 4'd0, 8'h40);
        check("R10", "no cs write ignored", {7'b0, led_red}, 8'h00);
        bus_write(1'b1, 4'd4, 8'h40);
        check("R10", "high address write ignored", {7'b0, led_red}, 8'h00);
        bus_read(1'b1, 4'd4, v); check("R10", "high address reads 0", v, 8'h00);
        bus_read(1'b0, 4'd0, v); check("R10", "read without cs", v, 8'h00);
        bus_read(1'b1, 4'd0, v); check("R10", "LED unchanged", v, 8'h30);
    endtask

    initial begin : watchdog
        #1_000_000;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait_cycles(3);
        rst = 1'b0;
        wait_cycles(1);
        t_reset();
        t_decode();
        t_led();
        t_i2c();
        t_wdog_bank();
        t_cfg();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule